// File: doc/BRIEF.md
# Transfer Request List Sequencer

This block steps through a list of equal-sized transfer request records that sit in a descriptor in memory. A start strobe presents two header words and the descriptor base address. The block checks that the descriptor is of the transfer-request kind, takes the record size from the second word, and takes the last record index, the reload index and the reload count from the first. It then asks a downstream executor for one record at a time. It holds a request carrying the record's byte address and index until the executor answers with a one-cycle done strobe, and only then moves on to the next record.

When the executor finishes the last record of a pass, the block takes one of three paths, depending on a reload counter loaded from the header. It can jump back to the reload index and start another pass. It can loop without end when the count holds the reserved forever value. Otherwise it finishes and raises a one-cycle completion pulse. A synchronous abort drops the block back to idle at any time. A descriptor that fails the checks produces a one-cycle error pulse, and no record is requested.

Top module: `tls_sequencer`

## Requirements
- R1: After reset, rec_req, done and err are all low and rec_idx is 0.
- R2: A start whose first header word has bits 31:30 other than 3 gives err high for exactly the one cycle after that start, and no record is requested.
- R3: A start whose record-size code (bits 26:24 of the second header word) exceeds 3 is rejected in the same way as R2.
- R4: While a record is requested, rec_addr equals base + (rec_idx + 1) × (16 << code). Codes 0, 1, 2 and 3 select 16, 32, 64 and 128 bytes, and the slot ahead of record 0 is the packet info block.
- R5: Records are requested one at a time. The first record is index 0. rec_idx holds steady until rec_done is seen, and after a done on an index below the last index, the next request carries the index plus one.
- R6: The last index comes from bits 13:0 of the first header word. A done on any index equal to or above it ends the pass.
- R7: The reload index comes from bits 19:14 and the reload count from bits 28:20. A count N below 0x1FF gives N extra passes, and each starts at the reload index. A count of 0 gives a single pass.
- R8: A reload count of 0x1FF makes the list return to the reload index after every pass, with no end.
- R9: After the final done, done is high for exactly one cycle and rec_req is low in that same cycle.
- R10: Abort sends the block to idle in the next cycle, with rec_req low and no done pulse. Abort overrides start and rec_done.
- R11: A start while a list is active is ignored. The header inputs are captured at the accepted start, so later changes to them have no effect on the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a list with the header words and base presented this cycle |
| hdr0 | input | 32 | First header word: kind, reload count, reload index, last index |
| hdr1 | input | 32 | Second header word: record-size code |
| base | input | AW | Byte address of the descriptor |
| abort | input | 1 | Synchronous abort back to idle |
| rec_req | output | 1 | A record fetch is requested |
| rec_addr | output | AW | Byte address of the requested record |
| rec_idx | output | 14 | Index of the requested record |
| rec_done | input | 1 | Executor finished the requested record |
| done | output | 1 | One-cycle pulse when the list completes |
| err | output | 1 | One-cycle pulse when a start is rejected |

## Verification
The bench builds the block with its default parameters: a 32-bit address and the full 14-bit index, 6-bit reload index and 9-bit reload count fields. With these, every size code and the reserved forever count can be reached. Random descriptors use short lists, reload indices that sometimes lie beyond the last index, and small reload counts, so that multi-pass walks finish quickly. Directed cases cover the single-record list, the forever loop stopped by abort, and a restart attempt with a bad header in the middle of a list.

// File: rtl/tls_pkg.sv
package tls_pkg;

    // header field layout (bit positions decoded by this block)
    localparam int KIND_LSB      = 30;
    localparam int KIND_W        = 2;
    localparam int KIND_TR       = 3;
    localparam int LAST_LSB      = 0;
    localparam int LAST_W        = 14;
    localparam int RIDX_LSB      = 14;
    localparam int RIDX_W        = 6;
    localparam int RCNT_LSB      = 20;
    localparam int RCNT_W        = 9;
    localparam int SZ_LSB        = 24;
    localparam int SZ_W          = 3;
    localparam int SZ_MAX_CODE   = 3;
    localparam int SZ_BASE_SHIFT = 4;
    localparam logic [RCNT_W-1:0] RCNT_FOREVER = {RCNT_W{1'b1}};

    typedef struct packed {
        logic [LAST_W-1:0] last;
        logic [RIDX_W-1:0] ridx;
        logic [RCNT_W-1:0] rcnt;
        logic [SZ_W-1:0]   szc;
    } list_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } walk_st_t;

    typedef enum logic [1:0] {
        NX_STEP   = 2'd0,
        NX_RELOAD = 2'd1,
        NX_LOOP   = 2'd2,
        NX_END    = 2'd3
    } step_kind_t;

    function automatic list_cfg_t unpack_hdr(input logic [31:0] w0, input logic [31:0] w1);
        list_cfg_t c;
        c.last = w0[LAST_LSB +: LAST_W];
        c.ridx = w0[RIDX_LSB +: RIDX_W];
        c.rcnt = w0[RCNT_LSB +: RCNT_W];
        c.szc  = w1[SZ_LSB +: SZ_W];
        return c;
    endfunction

    // action taken when the executor finishes record idx
    function automatic step_kind_t classify(input logic [LAST_W-1:0] idx,
                                            input list_cfg_t cfg,
                                            input logic [RCNT_W-1:0] rem);
        if (idx < cfg.last)              return NX_STEP;
        else if (cfg.rcnt == RCNT_FOREVER) return NX_LOOP;
        else if (rem != '0)              return NX_RELOAD;
        else                             return NX_END;
    endfunction

endpackage

// File: rtl/tls_hdr_decode.sv
module tls_hdr_decode
    import tls_pkg::*;
(
    input  logic [31:0] hdr0,
    input  logic [31:0] hdr1,
    output list_cfg_t   cfg,
    output logic        hdr_ok
);
    logic kind_ok;
    logic size_ok;
    logic unused_bits;

    always_comb begin
        cfg     = unpack_hdr(hdr0, hdr1);
        kind_ok = (hdr0[KIND_LSB +: KIND_W] == KIND_W'(KIND_TR));
        size_ok = (cfg.szc <= SZ_W'(SZ_MAX_CODE));
        hdr_ok  = kind_ok && size_ok;
    end

    assign unused_bits = ^{hdr0[29], hdr1[31:27], hdr1[23:0]};

endmodule

// File: rtl/tls_addr_gen.sv
module tls_addr_gen
    import tls_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]     base,
    input  logic [LAST_W-1:0] idx,
    input  logic [SZ_W-1:0]   szc,
    output logic [AW-1:0]     addr
);
    localparam int OFF_W = LAST_W + 1 + SZ_BASE_SHIFT + SZ_MAX_CODE;

    logic [OFF_W-1:0] slot;
    logic [OFF_W-1:0] off;
    logic             unused_szc;

    // slot 0 holds the packet info block, so record n lives in slot n+1
    always_comb begin
        slot = OFF_W'(idx) + OFF_W'(1);
        off  = slot << (SZ_BASE_SHIFT + int'(szc[1:0]));
    end

    assign addr       = base + AW'(off);
    assign unused_szc = szc[2];

endmodule

// File: rtl/tls_walk_ctrl.sv
module tls_walk_ctrl
    import tls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              rec_done,
    input  list_cfg_t         cfg_in,
    input  logic              hdr_ok,
    output list_cfg_t         cfg_q,
    output logic [LAST_W-1:0] idx_q,
    output logic              rec_req,
    output logic              done,
    output logic              err
);
    walk_st_t          st_q;
    logic [RCNT_W-1:0] rem_q;
    step_kind_t        nx;

    assign rec_req = (st_q == ST_RUN);
    assign nx      = classify(idx_q, cfg_q, rem_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            rem_q <= '0;
            cfg_q <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (abort) begin
                st_q  <= ST_IDLE;
                idx_q <= '0;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        if (start) begin
                            if (hdr_ok) begin
                                cfg_q <= cfg_in;
                                rem_q <= cfg_in.rcnt;
                                idx_q <= '0;
                                st_q  <= ST_RUN;
                            end else begin
                                err <= 1'b1;
                            end
                        end
                    end
                    ST_RUN: begin
                        if (rec_done) begin
                            case (nx)
                                NX_STEP:   idx_q <= idx_q + LAST_W'(1);
                                NX_LOOP:   idx_q <= LAST_W'(cfg_q.ridx);
                                NX_RELOAD: begin
                                    idx_q <= LAST_W'(cfg_q.ridx);
                                    rem_q <= rem_q - RCNT_W'(1);
                                end
                                default: begin
                                    st_q <= ST_IDLE;
                                    done <= 1'b1;
                                end
                            endcase
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        done |-> !rec_req); // R9
    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        err |-> !rec_req); // R2
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!rec_req && !done)); // R10
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rec_req && !rec_done && !abort) |=> (rec_req && $stable(idx_q))); // R5
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (rec_req && rec_done && !abort && idx_q < cfg_q.last) |=> (idx_q == $past(idx_q) + LAST_W'(1))); // R5
    AST_RELOAD_DEC: assert property (@(posedge clk) disable iff (rst)
        (rec_req && rec_done && !abort && idx_q >= cfg_q.last && cfg_q.rcnt != RCNT_FOREVER && rem_q != '0)
        |=> (rem_q == $past(rem_q) - RCNT_W'(1) && idx_q == LAST_W'(cfg_q.ridx))); // R7
    AST_FOREVER_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (rec_req && cfg_q.rcnt == RCNT_FOREVER) |=> !done); // R8

endmodule

// File: rtl/tls_sequencer.sv
module tls_sequencer
    import tls_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       hdr0,
    input  logic [31:0]       hdr1,
    input  logic [AW-1:0]     base,
    input  logic              abort,
    output logic              rec_req,
    output logic [AW-1:0]     rec_addr,
    output logic [LAST_W-1:0] rec_idx,
    input  logic              rec_done,
    output logic              done,
    output logic              err
);
    list_cfg_t     cfg_dec;
    list_cfg_t     cfg_q;
    logic          hdr_ok;
    logic [AW-1:0] base_q;

    tls_hdr_decode u_dec (
        .hdr0   (hdr0),
        .hdr1   (hdr1),
        .cfg    (cfg_dec),
        .hdr_ok (hdr_ok)
    );

    tls_walk_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .rec_done (rec_done),
        .cfg_in   (cfg_dec),
        .hdr_ok   (hdr_ok),
        .cfg_q    (cfg_q),
        .idx_q    (rec_idx),
        .rec_req  (rec_req),
        .done     (done),
        .err      (err)
    );

    // base is captured with the header at an accepted start
    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (start && !rec_req && !abort && hdr_ok)
            base_q <= base;
    end

    tls_addr_gen #(.AW(AW)) u_addr (
        .base (base_q),
        .idx  (rec_idx),
        .szc  (cfg_q.szc),
        .addr (rec_addr)
    );

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err || $past(start)); // R2
    AST_ADDR_ABOVE_BASE: assert property (@(posedge clk) disable iff (rst)
        rec_req |-> (rec_addr > base_q || rec_addr < base_q)); // R4

endmodule

// File: tb/sim_tls_sequencer.sv
module sim_tls_sequencer;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start = 1'b0;
    logic [31:0]   hdr0 = '0;
    logic [31:0]   hdr1 = '0;
    logic [AW-1:0] base = '0;
    logic          abort = 1'b0;
    logic          rec_req;
    logic [AW-1:0] rec_addr;
    logic [13:0]   rec_idx;
    logic          rec_done = 1'b0;
    logic          done;
    logic          err;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;

    tls_sequencer #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .start(start), .hdr0(hdr0), .hdr1(hdr1),
        .base(base), .abort(abort), .rec_req(rec_req), .rec_addr(rec_addr),
        .rec_idx(rec_idx), .rec_done(rec_done), .done(done), .err(err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] mk_h0(int kind, int last, int ridx, int rcnt);
        return (32'(kind) << 30) | ((32'(rcnt) & 32'h1FF) << 20) |
               ((32'(ridx) & 32'h3F) << 14) | (32'(last) & 32'h3FFF);
    endfunction

    function automatic logic [31:0] mk_h1(int code);
        return (32'(code) & 32'h7) << 24;
    endfunction

    function automatic logic [31:0] exp_addr(logic [31:0] b, int idx, int code);
        return b + ((32'(idx) + 32'd1) << (4 + code));
    endfunction

    task automatic do_start(input logic [31:0] h0, input logic [31:0] h1, input logic [31:0] b);
        @(negedge clk);
        hdr0 = h0; hdr1 = h1; base = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Walks one list, acting as the executor. abort_at: abort after that many records (0 = none).
    task automatic run_list(input int last, input int ridx, input int rcnt, input int code,
                            input logic [31:0] b, input int abort_at, input bit mid_start,
                            input int exp_total, input string tag);
        int m_idx = 0;
        int m_rem = rcnt;
        int seen  = 0;
        bit fin   = 0;
        logic [31:0] h0 = mk_h0(3, last, ridx, rcnt);
        do_start(h0, mk_h1(code), b);
        while (!fin) begin
            chk("R5 req", rec_req, 1);
            chk("R5 idx", rec_idx, m_idx);
            chk("R4 addr", rec_addr, exp_addr(b, m_idx, code));
            chk("R9 no early done", done, 0);
            if (mid_start && seen == 0) begin
                // R11: bad header plus new base while busy must be ignored
                hdr0 = 32'h0; base = 32'hFFFF_0000; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk("R11 err", err, 0);
                chk("R11 idx", rec_idx, m_idx);
                chk("R11 addr", rec_addr, exp_addr(b, m_idx, code));
            end
            seen++;
            if (abort_at != 0 && seen == abort_at) begin
                abort = 1'b1; rec_done = 1'b1;
                @(negedge clk);
                abort = 1'b0; rec_done = 1'b0;
                chk("R10 req", rec_req, 0);
                chk("R10 done", done, 0);
                repeat (3) begin
                    @(negedge clk);
                    chk("R10 quiet", {rec_req, done}, 0);
                end
                fin = 1;
            end else begin
                repeat ($urandom % 3) @(negedge clk);
                rec_done = 1'b1;
                @(negedge clk);
                rec_done = 1'b0;
                if (m_idx < last) m_idx++;
                else if (rcnt == 511) m_idx = ridx;
                else if (m_rem > 0) begin m_rem--; m_idx = ridx; end
                else begin
                    chk("R9 done", done, 1);
                    chk("R9 req low", rec_req, 0);
                    @(negedge clk);
                    chk("R9 one cycle", done, 0);
                    fin = 1;
                end
            end
        end
        if (exp_total >= 0) chk(tag, seen, exp_total);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset", {rec_req, done, err}, 0);
        chk("R1 idx", rec_idx, 0);

        // R2: wrong descriptor kind
        do_start(mk_h0(2, 3, 0, 0), mk_h1(0), 32'h1000);
        chk("R2 err", err, 1);
        chk("R2 no req", rec_req, 0);
        @(negedge clk);
        chk("R2 err pulse", err, 0);
        chk("R2 still idle", rec_req, 0);

        // R3: bad size code
        do_start(mk_h0(3, 3, 0, 0), mk_h1(5), 32'h1000);
        chk("R3 err", err, 1);
        chk("R3 no req", rec_req, 0);
        @(negedge clk);

        // single record list
        run_list(0, 0, 0, 0, 32'h2000, 0, 0, 1, "R6 single");
        // one pass of four records, 128-byte records
        run_list(3, 0, 0, 3, 32'h4000_0000, 0, 0, 4, "R6 pass end");
        // reload twice from index 1: 0 1 2 1 2 1 2
        run_list(2, 1, 2, 1, 32'h8000, 0, 0, 7, "R7 reload");
        // reload index beyond last: 0 1 5 5
        run_list(1, 5, 2, 2, 32'h100, 0, 0, 4, "R6 ridx above last");
        // forever loop, stopped by abort
        run_list(2, 1, 511, 0, 32'h3000, 11, 0, 11, "R8 forever");
        // start while busy ignored
        run_list(2, 0, 1, 2, 32'hA000, 0, 1, 6, "R11 busy start");
        // abort in a finite list
        run_list(4, 0, 0, 1, 32'h5000, 2, 0, 2, "R10 abort");

        for (int i = 0; i < 20; i++) begin
            int l = $urandom % 6;
            int r = $urandom % 8;
            int c = $urandom % 4;
            int z = $urandom % 4;
            int tot = (l + 1) + c * ((r <= l) ? (l - r + 1) : 1);
            run_list(l, r, c, z, $urandom & 32'hFFFF_FFF0, 0, 0, tot, "R7 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule